// File: doc/BRIEF.md
# Dirty Plane Tracker With Re-entry Timer

This block sits beside a panel self-refresh engine and decides when that engine has to wake up and when it may go back to sleep. Rendering activity reaches it as two single-cycle events that carry a plane mask. An invalidate event means rendering into those planes has started. A flush event means the rendering has reached memory. The block ignores planes that the pipe driving the panel does not own. It keeps a register of dirty planes and raises a one-cycle exit request whenever a relevant plane is touched.

After a flush, the block may arm a re-entry timer counted in milliseconds. This happens when self-refresh is not active, nothing is dirty and no timer is already running. When the timer expires, the block waits a bounded number of cycles for the engine to report idle. It then checks the dirty register once more and raises a one-cycle activate request only if the register is still clean. When the feature is switched on, the first activation is held back by five panel power-cycle delays. A clock-rate parameter turns milliseconds into cycles, so a bench can shrink every delay.

Top module: `refresh_idle_tracker`

## Requirements
- R1: The plane mask of an event is ANDed with `pipe_mask` before use, so bits outside the driving pipe change neither `busy_mask` nor `exit_req`.
- R2: An invalidate ORs the masked planes into `busy_mask`. If the masked value is nonzero, `exit_req` is high in the cycle after the event.
- R3: A flush clears the masked planes from `busy_mask`. If the masked value is nonzero, it also raises `exit_req` in the next cycle.
- R4: A flush arms the re-entry timer for REENTRY_MS milliseconds when all of these hold: `sr_active` is low, the updated `busy_mask` is zero, and no timer or idle wait is in progress. A timer that is already running is not restarted.
- R5: After expiry, the block waits up to IDLE_WAIT cycles for `sr_idle`. If `sr_idle` does not arrive in that window, the re-entry is dropped without an activate. A later `sr_idle` has no effect.
- R6: When `sr_idle` is seen, `busy_mask` is checked again. Any plane that became dirty during the delay suppresses `activate_req`.
- R7: When `en` rises, `busy_mask` is cleared and the timer is armed for 5*PWR_CYCLE_MS milliseconds. Activation happens only after that delay expires.
- R8: While `en` is low, events are ignored, `busy_mask` holds its value and any pending timer or idle wait is cancelled.
- R9: An invalidate and a flush in the same cycle are applied in that order: busy = (busy | m) & ~m, with m the masked plane value. `exit_req` is raised if m is nonzero.
- R10: `exit_req` and `activate_req` are registered one-cycle pulses. `activate_req` is never raised when `sr_active` was high in the deciding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Feature enable |
| sr_active | input | 1 | Self-refresh currently active |
| sr_idle | input | 1 | Engine reports its idle state |
| pipe_mask | input | PLANES | Planes owned by the pipe driving the panel |
| plane_mask | input | PLANES | Planes named by the current event |
| inv_evt | input | 1 | Invalidate event pulse |
| flush_evt | input | 1 | Flush event pulse |
| exit_req | output | 1 | One-cycle request to leave self-refresh |
| activate_req | output | 1 | One-cycle request to enter self-refresh |
| busy_mask | output | PLANES | Dirty-plane register |

## Verification
The tests use plane masks that fall wholly outside the pipe, partly inside it and wholly inside it. This separates the masking step from the set and clear logic. Flushes are applied in several situations: while self-refresh is active, with a plane still dirty, with a timer already running, and with an invalidate arriving in the middle of the delay. Each one must either arm or not arm the timer, and the bench tells them apart by when activation appears, if it appears at all. The idle handshake is tried in three ways: idle that never comes, idle that comes too late, and idle that comes inside the window. Enabling and disabling is checked for clearing busy, cancelling the timer and ignoring events.

// File: rtl/refresh_idle_tracker.sv
module refresh_idle_tracker #(
  parameter int PLANES       = 16,
  parameter int CLK_HZ       = 50_000_000,
  parameter int REENTRY_MS   = 100,
  parameter int PWR_CYCLE_MS = 500,
  parameter int IDLE_WAIT    = 1_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sr_active,
  input  logic              sr_idle,
  input  logic [PLANES-1:0] pipe_mask,
  input  logic [PLANES-1:0] plane_mask,
  input  logic              inv_evt,
  input  logic              flush_evt,
  output logic              exit_req,
  output logic              activate_req,
  output logic [PLANES-1:0] busy_mask
);

  localparam int MS_CYC   = (CLK_HZ >= 2000) ? CLK_HZ / 1000 : 1;
  localparam int FIRST_MS = 5 * PWR_CYCLE_MS;
  localparam int MAX_MS   = (FIRST_MS > REENTRY_MS) ? FIRST_MS : REENTRY_MS;
  localparam int PW       = $clog2(MS_CYC + 1);
  localparam int MW       = $clog2(MAX_MS + 1);
  localparam int IW       = $clog2(IDLE_WAIT + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_COUNT, ST_WAIT} st_t;

  st_t             st;
  logic            en_q;
  logic [PW-1:0]   pre;
  logic [MW-1:0]   ms, tgt;
  logic [IW-1:0]   iw;

  wire [PLANES-1:0] sel    = plane_mask & pipe_mask;
  wire [PLANES-1:0] inv_m  = inv_evt   ? sel : '0;
  wire [PLANES-1:0] fl_m   = flush_evt ? sel : '0;
  wire [PLANES-1:0] busy_nx = (busy_mask | inv_m) & ~fl_m;
  wire              en_rise = en & ~en_q;
  wire              arm     = flush_evt & ~sr_active & (busy_nx == '0);
  wire              ms_tick = (pre == PW'(MS_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      en_q         <= 1'b0;
      pre          <= '0;
      ms           <= '0;
      tgt          <= '0;
      iw           <= '0;
      busy_mask    <= '0;
      exit_req     <= 1'b0;
      activate_req <= 1'b0;
    end else begin
      en_q         <= en;
      exit_req     <= 1'b0;
      activate_req <= 1'b0;
      if (!en) begin
        st <= ST_IDLE;
      end else if (en_rise) begin
        busy_mask <= '0;
        st        <= ST_COUNT;
        pre       <= '0;
        ms        <= '0;
        tgt       <= MW'(FIRST_MS);
      end else begin
        busy_mask <= busy_nx;
        exit_req  <= |(inv_m | fl_m);
        case (st)
          ST_IDLE:
            if (arm) begin
              st  <= ST_COUNT;
              pre <= '0;
              ms  <= '0;
              tgt <= MW'(REENTRY_MS);
            end
          ST_COUNT:
            if (ms_tick) begin
              pre <= '0;
              if (ms == tgt - MW'(1)) begin
                st <= ST_WAIT;
                iw <= '0;
              end else begin
                ms <= ms + MW'(1);
              end
            end else begin
              pre <= pre + PW'(1);
            end
          ST_WAIT:
            if (sr_idle) begin
              st           <= ST_IDLE;
              activate_req <= (busy_nx == '0) & ~sr_active;
            end else if (iw == IW'(IDLE_WAIT - 1)) begin
              st <= ST_IDLE;
            end else begin
              iw <= iw + IW'(1);
            end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/refresh_idle_tracker_chk.sv
module refresh_idle_tracker_chk #(
  parameter int PLANES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              sr_active,
  input logic              inv_evt,
  input logic              flush_evt,
  input logic              exit_req,
  input logic              activate_req,
  input logic [PLANES-1:0] busy_mask
);

  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (!exit_req && !activate_req));

  a_r8_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (busy_mask == $past(busy_mask)));

  a_r10_act_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    activate_req |=> !activate_req);

  a_r10_act_not_active: assert property (@(posedge clk) disable iff (!rst_n)
    activate_req |-> !$past(sr_active));

  a_r6_act_clean: assert property (@(posedge clk) disable iff (!rst_n)
    activate_req |-> (busy_mask == '0));

  a_r2_exit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |-> $past(inv_evt || flush_evt));

endmodule

bind refresh_idle_tracker refresh_idle_tracker_chk #(.PLANES(PLANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sr_active(sr_active),
  .inv_evt(inv_evt), .flush_evt(flush_evt), .exit_req(exit_req),
  .activate_req(activate_req), .busy_mask(busy_mask)
);

// File: tb/refresh_idle_tracker_tb.sv
`timescale 1ns/1ps
module refresh_idle_tracker_tb;
  localparam int P = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0, sr_active = 1'b0, sr_idle = 1'b0;
  logic [P-1:0] pipe_mask = '0, plane_mask = '0;
  logic         inv_evt = 1'b0, flush_evt = 1'b0;
  logic         exit_req, activate_req;
  logic [P-1:0] busy_mask;
  int           total = 0, bad = 0;

  always #10 clk = ~clk;

  refresh_idle_tracker #(.PLANES(P), .CLK_HZ(10_000), .REENTRY_MS(100),
                         .PWR_CYCLE_MS(4), .IDLE_WAIT(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .sr_active(sr_active), .sr_idle(sr_idle),
    .pipe_mask(pipe_mask), .plane_mask(plane_mask), .inv_evt(inv_evt),
    .flush_evt(flush_evt), .exit_req(exit_req), .activate_req(activate_req),
    .busy_mask(busy_mask));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ev(input bit i, input bit f, input logic [P-1:0] pm);
    @(negedge clk); inv_evt = i; flush_evt = f; plane_mask = pm;
    @(negedge clk); inv_evt = 0; flush_evt = 0; plane_mask = '0;
  endtask

  task automatic expect_out(input bit ex, input logic [P-1:0] bz, input string req);
    check(exit_req == ex, req, int'(exit_req), int'(ex));
    check(busy_mask == bz, req, int'(busy_mask), int'(bz));
  endtask

  task automatic wait_act(input int lo, input int hi, input string req);
    int c = 0;
    while (c <= hi && !activate_req) begin
      @(negedge clk); c++;
    end
    check(activate_req && c >= lo && c <= hi, req, c, lo);
    @(negedge clk);
    check(!activate_req, "R10", int'(activate_req), 0);
  endtask

  task automatic no_act(input int n, input string req);
    int seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (activate_req) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out(1'b0, '0, "R10");
    check(!activate_req, "R10", int'(activate_req), 0);
  endtask

  task automatic t_disabled();
    pipe_mask = 8'h0F;
    ev(1'b1, 1'b0, 8'h01);
    expect_out(1'b0, '0, "R8");
  endtask

  task automatic t_first();
    sr_idle = 1'b1; sr_active = 1'b0;
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    wait_act(198, 205, "R7");
    sr_active = 1'b1;
  endtask

  task automatic t_mask();
    ev(1'b1, 1'b0, 8'h30);
    expect_out(1'b0, '0, "R1");
    ev(1'b1, 1'b0, 8'h35);
    expect_out(1'b1, 8'h05, "R2");
    @(negedge clk);
    check(!exit_req, "R10", int'(exit_req), 0);
  endtask

  task automatic t_flush();
    ev(1'b0, 1'b1, 8'h01);
    expect_out(1'b1, 8'h04, "R3");
    no_act(1100, "R4");
    sr_active = 1'b0;
    ev(1'b0, 1'b1, 8'h04);
    expect_out(1'b1, '0, "R3");
    wait_act(998, 1005, "R4");
  endtask

  task automatic t_norestart();
    ev(1'b0, 1'b1, 8'h00);
    expect_out(1'b0, '0, "R4");
    repeat (500) @(negedge clk);
    ev(1'b0, 1'b1, 8'h00);
    wait_act(496, 503, "R4");
  endtask

  task automatic t_race();
    ev(1'b0, 1'b1, 8'h00);
    repeat (500) @(negedge clk);
    ev(1'b1, 1'b0, 8'h02);
    expect_out(1'b1, 8'h02, "R6");
    no_act(700, "R6");
    ev(1'b0, 1'b1, 8'h02);
    expect_out(1'b1, '0, "R6");
    wait_act(998, 1005, "R6");
  endtask

  task automatic t_idle();
    sr_idle = 1'b0;
    ev(1'b0, 1'b1, 8'h00);
    no_act(1100, "R5");
    sr_idle = 1'b1;
    no_act(50, "R5");
    sr_idle = 1'b0;
    ev(1'b0, 1'b1, 8'h00);
    repeat (1005) @(negedge clk);
    sr_idle = 1'b1;
    wait_act(0, 4, "R5");
  endtask

  task automatic t_active_block();
    ev(1'b0, 1'b1, 8'h00);
    repeat (900) @(negedge clk);
    sr_active = 1'b1;
    no_act(200, "R10");
  endtask

  task automatic t_same();
    ev(1'b1, 1'b0, 8'h08);
    expect_out(1'b1, 8'h08, "R9");
    ev(1'b1, 1'b1, 8'h01);
    expect_out(1'b1, 8'h08, "R9");
    ev(1'b1, 1'b1, 8'h08);
    expect_out(1'b1, '0, "R9");
  endtask

  task automatic t_cancel();
    sr_active = 1'b0;
    ev(1'b0, 1'b1, 8'h00);
    repeat (300) @(negedge clk);
    en = 1'b0;
    ev(1'b1, 1'b0, 8'h04);
    expect_out(1'b0, '0, "R8");
    no_act(1000, "R8");
    en = 1'b1;
    @(negedge clk);
    ev(1'b1, 1'b0, 8'h04);
    expect_out(1'b1, 8'h04, "R8");
    en = 1'b0;
    repeat (3) @(negedge clk);
    check(busy_mask == 8'h04, "R8", int'(busy_mask), 4);
    en = 1'b1;
    repeat (2) @(negedge clk);
    check(busy_mask == '0, "R8", int'(busy_mask), 0);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_first();
    t_mask();
    t_flush();
    t_norestart();
    t_race();
    t_idle();
    t_active_block();
    t_same();
    t_cancel();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule